// File: doc/BRIEF.md
# Unaligned Receive Buffer Writer

This block sits between a receive FIFO and system memory. The FIFO hands it received frame data as full-width words. The last word of a frame is flagged, and that word carries a count of its valid bytes. A descriptor source supplies buffers one at a time. Each buffer is a start byte address, which may have any alignment, and a size in bytes. The block steers the frame bytes into the buffers and issues only word-aligned memory writes. A per-lane byte enable marks which lanes carry frame bytes. The other lanes are driven with a fixed dummy byte, so the memory side may honour the enables or ignore them.

A buffer is closed when it fills or when the frame ends, whichever comes first. Its status word is then emitted with the ownership bit cleared. The status word also carries a flag for the first buffer of a frame and a flag for the buffer that holds the frame end. The last buffer's status also carries the total frame length. When the current buffer closes, the block raises a descriptor request. It stops taking FIFO words until a new buffer is supplied. Each new frame starts in a fresh buffer.

Top module: `rxbuf_writer`

## Requirements
- R1: Every memory write has a word-aligned address (`wr_addr[1:0] == 0`). Frame byte k of a buffer starting at byte address A is written to word address (A+k) with the low two bits cleared, on lane (A+k) mod 4.
- R2: Only lanes that carry frame bytes have their byte enable set. A buffer at 0x0002 receiving 15 bytes takes exactly 5 writes: the first has enables 4'b1100 and the last has 4'b0001. A buffer of u bytes at offset o takes (o+u+3)/4 writes.
- R3: A buffer's usable capacity is its size minus its start offset (address mod 4). Bytes beyond that capacity continue in the next buffer, with frame byte order kept.
- R4: A buffer is closed at fill or at frame end, whichever comes first, and exactly one status word is emitted per buffer. A status without the last flag belongs to a buffer filled to its full capacity.
- R5: A new frame always starts in a newly supplied buffer. No byte of a frame is written into a buffer used by an earlier frame.
- R6: Status bit 31 (ownership) is always 0. Bit 9 is set only on the first buffer of a frame. Bit 8 is set only on the buffer holding the frame end. All other bits outside [29:16] and bit 7 are 0.
- R7: Status bits [29:16] hold the frame's total byte count on the last buffer and are 0 on every other buffer.
- R8: While no buffer is held, `desc_req` is high and no more than one FIFO word is accepted. After that, `in_ready` stays low until a descriptor is taken.
- R9: The frame length saturates at 16383. Status bit 7 is set on the last buffer of a frame that exceeded 16383 bytes. Both are cleared for the next frame.
- R10: After reset, `desc_req` and `in_ready` are 1 and `wr_valid` and `st_valid` are 0.
- R11: On the end-of-frame word, `in_cnt` (1 to 4) gives the number of valid low-order bytes. Bytes beyond that count, and lanes outside a buffer, are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | FIFO word available |
| in_ready | output | 1 | Block accepts the FIFO word this cycle |
| in_data | input | 32 | FIFO word, byte 0 in bits [7:0] first in frame order |
| in_eof | input | 1 | This word ends the frame |
| in_cnt | input | 3 | Valid bytes in the end-of-frame word (1 to 4) |
| desc_req | output | 1 | Block holds no buffer and wants one |
| desc_valid | input | 1 | Descriptor presented |
| desc_addr | input | 16 | Buffer start byte address, any alignment |
| desc_size | input | 14 | Buffer size in bytes (greater than the start offset) |
| wr_valid | output | 1 | Memory write this cycle |
| wr_addr | output | 16 | Word-aligned write address |
| wr_data | output | 32 | Write data, dummy byte on disabled lanes |
| wr_be | output | 4 | Per-lane byte enable |
| st_valid | output | 1 | Status word for a closed buffer |
| st_word | output | 32 | Status: ownership, length, first, last, overflow |

## Verification
The bench goes after offsets of 1, 2 and 3. With these, one FIFO word spans two memory words and often a buffer boundary too. A wrong steering step would drop or duplicate bytes there, and a wrong enable would overwrite the sentinel bytes before the buffer start or after the frame end. It also covers a frame that fills its buffer exactly, a one-byte frame and a frame that runs past the length field. These show a last flag set on a full non-final buffer, a length reported on a middle buffer, or a counter that wraps instead of saturating. Delayed descriptors check that the FIFO stalls and that data is neither lost nor spilled into the previous frame's buffer.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
   localparam int ST_OWN_BIT   = 31;
   localparam int ST_LEN_LSB   = 16;
   localparam int ST_LEN_MAXW  = 14;
   localparam int ST_FIRST_BIT = 9;
   localparam int ST_LAST_BIT  = 8;
   localparam int ST_OVF_BIT   = 7;
endpackage

// File: rtl/rxw_lane_pack.sv
module rxw_lane_pack #(
   parameter int NB = 4
) (
   input  logic [8*NB-1:0]            src,
   input  logic [$clog2(NB)-1:0]      lane,
   input  logic [$clog2(NB+1)-1:0]    take,
   output logic [8*NB-1:0]            put_d,
   output logic [NB-1:0]              put_be
);
   localparam int LB = $clog2(NB);
   localparam int CW = $clog2(NB+1);

   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [LB-1:0]   sel;
      logic            hit;
      logic [8*NB-1:0] shifted;
      always_comb begin
         sel     = LB'(g) - lane;
         hit     = (CW'(g) >= CW'(lane)) && (CW'(g) < (CW'(lane) + take));
         shifted = src >> {sel, 3'b000};
         put_be[g]       = hit;
         put_d[8*g +: 8] = hit ? shifted[7:0] : 8'h00;
      end
   end
endmodule

// File: rtl/rxw_len_ctr.sv
module rxw_len_ctr #(
   parameter int LW = 14,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [CW-1:0] amt,
   input  logic          restart,
   output logic [LW-1:0] len_nxt,
   output logic          ovf_nxt
);
   localparam logic [LW-1:0] LMAX = '1;

   logic [LW-1:0] len_q;
   logic          ovf_q;
   logic [LW:0]   sum;

   always_comb begin
      sum     = {1'b0, len_q} + (LW+1)'(amt);
      len_nxt = sum[LW] ? LMAX : sum[LW-1:0];
      ovf_nxt = ovf_q | sum[LW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
         ovf_q <= 1'b0;
      end else if (step) begin
         if (restart) begin
            len_q <= '0;
            ovf_q <= 1'b0;
         end else begin
            len_q <= len_nxt;
            ovf_q <= ovf_nxt;
         end
      end
   end

   assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (len_q == LMAX));

   assert_len_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart) |=> (len_q >= $past(len_q)));
endmodule

// File: rtl/rxbuf_writer.sv
module rxbuf_writer
   import rxw_pkg::*;
#(
   parameter int         DW         = 32,
   parameter int         AW         = 16,
   parameter int         SW         = 14,
   parameter int         LW         = 14,
   parameter logic [7:0] DUMMY_BYTE = 8'h00
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [DW-1:0]             in_data,
   input  logic                      in_eof,
   input  logic [$clog2(DW/8+1)-1:0] in_cnt,
   output logic                      desc_req,
   input  logic                      desc_valid,
   input  logic [AW-1:0]             desc_addr,
   input  logic [SW-1:0]             desc_size,
   output logic                      wr_valid,
   output logic [AW-1:0]             wr_addr,
   output logic [DW-1:0]             wr_data,
   output logic [DW/8-1:0]           wr_be,
   output logic                      st_valid,
   output logic [31:0]               st_word
);
   localparam int NB = DW/8;
   localparam int LB = $clog2(NB);
   localparam int CW = $clog2(NB+1);

   if ((DW % 8) != 0 || NB < 2 || (NB & (NB-1)) != 0) begin : g_bad_dw
      $error("rxbuf_writer: DW must be a power-of-two byte count of at least 2 bytes");
   end
   if (LW < 1 || LW > ST_LEN_MAXW) begin : g_bad_lw
      $error("rxbuf_writer: LW must fit the status length field");
   end
   if (SW <= LB || AW <= LB) begin : g_bad_aw
      $error("rxbuf_writer: SW and AW must exceed the lane index width");
   end

   // buffer state
   logic          buf_v;
   logic [AW-1:0] cur_a;
   logic [SW-1:0] rem;
   logic          first_q;
   // pending FIFO word, next byte in the low lane
   logic          pend_v;
   logic [DW-1:0] pend_d;
   logic [CW-1:0] pend_n;
   logic          pend_eof;
   // partly assembled output word
   logic [DW-1:0] acc_d;
   logic [NB-1:0] acc_be;
   logic [DW-1:0] wr_raw;

   logic [LB-1:0] lane;
   logic [CW-1:0] room, take;
   logic          step, drain_all, buf_full, frm_end, close, flush, load, desc_take;
   logic [DW-1:0] put_d, mrg_d;
   logic [NB-1:0] put_be, mrg_be;
   logic [LW-1:0] len_nxt;
   logic          ovf_nxt;
   logic [31:0]   st_nxt;

   always_comb begin
      lane = cur_a[LB-1:0];
      room = CW'(NB) - CW'(lane);
      take = pend_n;
      if (room < take) take = room;
      if (rem < SW'(take)) take = CW'(rem);
      step      = buf_v && pend_v;
      drain_all = step && (take == pend_n);
      buf_full  = step && (rem == SW'(take));
      frm_end   = drain_all && pend_eof;
      close     = buf_full || frm_end;
      flush     = step && (((CW'(lane) + take) == CW'(NB)) || close);
      in_ready  = !pend_v || drain_all;
      load      = in_valid && in_ready;
      desc_req  = !buf_v;
      desc_take = desc_valid && !buf_v;
      mrg_d     = acc_d | put_d;
      mrg_be    = acc_be | put_be;
   end

   rxw_lane_pack #(.NB(NB)) u_pack (
      .src    (pend_d),
      .lane   (lane),
      .take   (take),
      .put_d  (put_d),
      .put_be (put_be)
   );

   rxw_len_ctr #(.LW(LW), .CW(CW)) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .amt     (take),
      .restart (frm_end),
      .len_nxt (len_nxt),
      .ovf_nxt (ovf_nxt)
   );

   always_comb begin
      st_nxt = '0;
      st_nxt[ST_OWN_BIT] = 1'b0;
      if (frm_end) st_nxt[ST_LEN_LSB +: LW] = len_nxt;
      st_nxt[ST_FIRST_BIT] = first_q;
      st_nxt[ST_LAST_BIT]  = frm_end;
      st_nxt[ST_OVF_BIT]   = frm_end & ovf_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_v    <= 1'b0;
         cur_a    <= '0;
         rem      <= '0;
         first_q  <= 1'b1;
         pend_v   <= 1'b0;
         pend_d   <= '0;
         pend_n   <= '0;
         pend_eof <= 1'b0;
         acc_d    <= '0;
         acc_be   <= '0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_raw   <= '0;
         wr_be    <= '0;
         st_valid <= 1'b0;
         st_word  <= '0;
      end else begin
         wr_valid <= flush;
         st_valid <= close;
         if (flush) begin
            wr_addr <= {cur_a[AW-1:LB], LB'(0)};
            wr_raw  <= mrg_d;
            wr_be   <= mrg_be;
         end
         if (close) st_word <= st_nxt;

         if (desc_take) begin
            buf_v <= 1'b1;
            cur_a <= desc_addr;
            rem   <= desc_size - SW'(desc_addr[LB-1:0]);
         end else if (step) begin
            cur_a <= cur_a + AW'(take);
            rem   <= rem - SW'(take);
            if (close) begin
               buf_v   <= 1'b0;
               first_q <= frm_end;
            end
         end

         if (step) begin
            acc_d  <= flush ? '0 : mrg_d;
            acc_be <= flush ? '0 : mrg_be;
         end

         if (load) begin
            pend_v   <= 1'b1;
            pend_d   <= in_data;
            pend_n   <= in_eof ? in_cnt : CW'(NB);
            pend_eof <= in_eof;
         end else if (step) begin
            pend_v <= !drain_all;
            pend_d <= pend_d >> {take, 3'b000};
            pend_n <= pend_n - take;
         end
      end
   end

   for (genvar g = 0; g < NB; g++) begin : g_out_lane
      assign wr_data[8*g +: 8] = wr_be[g] ? wr_raw[8*g +: 8] : DUMMY_BYTE;
   end

   assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr[LB-1:0] == '0));
   assert_be_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_be != '0));
   assert_desc_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_req) |-> (desc_size > SW'(desc_addr[LB-1:0])));
   assert_cap_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_v |-> (rem != '0));
   assert_close_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> wr_valid);
   assert_own_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> !st_word[ST_OWN_BIT]);
   assert_len_only_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_word[ST_LAST_BIT]) |-> (st_word[ST_LEN_LSB +: LW] == '0));
   assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_v && pend_v) |-> !in_ready);
   assert_cnt_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_eof) |-> ((in_cnt != '0) && (in_cnt <= CW'(NB))));
endmodule

// File: tb/rxbuf_writer_tb.sv
module rxbuf_writer_tb;
   localparam int DW = 32;
   localparam int AW = 16;
   localparam int SW = 14;
   localparam int LW = 14;

   // table: offset, size, stride, length, descriptor delay
   localparam logic [71:0] VEC [8] = '{
      {16'd2, 16'd64, 16'd256, 16'd15, 8'd0},
      {16'd0, 16'd16, 16'd256, 16'd40, 8'd0},
      {16'd3, 16'd10, 16'd256, 16'd30, 8'd0},
      {16'd1, 16'd9,  16'd256, 16'd8,  8'd0},
      {16'd2, 16'd6,  16'd256, 16'd1,  8'd0},
      {16'd0, 16'd4,  16'd256, 16'd4,  8'd0},
      {16'd3, 16'd5,  16'd256, 16'd9,  8'd3},
      {16'd1, 16'd12, 16'd256, 16'd50, 8'd20}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_ready, in_eof;
   logic [DW-1:0] in_data;
   logic [2:0]    in_cnt;
   logic          desc_req, desc_valid;
   logic [AW-1:0] desc_addr;
   logic [SW-1:0] desc_size;
   logic          wr_valid, st_valid;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [3:0]    wr_be;
   logic [31:0]   st_word;

   always #4 clk = ~clk;

   rxbuf_writer #(.DW(DW), .AW(AW), .SW(SW), .LW(LW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_eof(in_eof), .in_cnt(in_cnt),
      .desc_req(desc_req), .desc_valid(desc_valid),
      .desc_addr(desc_addr), .desc_size(desc_size),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .st_valid(st_valid), .st_word(st_word)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   logic [7:0]  mem [0:65535];
   int          wr_cnt, st_cnt, run_hs, max_hs;
   logic [31:0] st_log [0:15];
   logic [3:0]  first_be, last_be;
   bit          got_last;
   int          d_base, d_size, d_stride, d_delay;
   int          d_k = 0;
   int          d_limit = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   function automatic logic [7:0] fb(input int fid, input int i);
      return 8'((i * 7) + (fid * 29) + (i >> 8));
   endfunction

   // monitor: memory model, status log, stall measurement, watchdog
   always @(negedge clk) begin
      #2;
      cyc++;
      if (wr_valid) begin
         for (int b = 0; b < 4; b++)
            if (wr_be[b]) mem[int'(wr_addr) + b] = wr_data[8*b +: 8];
         if (wr_cnt == 0) first_be = wr_be;
         last_be = wr_be;
         wr_cnt++;
      end
      if (st_valid) begin
         if (st_cnt < 16) st_log[st_cnt] = st_word;
         st_cnt++;
         if (st_word[8]) got_last = 1'b1;
      end
      if (desc_req) begin
         if (in_valid && in_ready) run_hs++;
         if (run_hs > max_hs) max_hs = run_hs;
      end else begin
         run_hs = 0;
      end
      if (cyc > 190000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         summary();
         $finish;
      end
   end

   // descriptor source
   initial begin
      desc_valid = 1'b0;
      desc_addr  = '0;
      desc_size  = '0;
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && desc_req && d_k < d_limit) begin
            repeat (d_delay) @(negedge clk);
            desc_addr  = AW'(d_base + d_k * d_stride);
            desc_size  = SW'(d_size);
            desc_valid = 1'b1;
            @(posedge clk);
            #1 desc_valid = 1'b0;
            d_k++;
         end
      end
   end

   task automatic send_frame(input int fid, input int len, input bit gap);
      int nw;
      logic [31:0] d;
      bit rdy;
      nw = (len + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         if (gap && (w % 3) == 2) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         for (int b = 0; b < 4; b++)
            d[8*b +: 8] = (4*w + b < len) ? fb(fid, 4*w + b) : 8'hAA;
         do begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = d;
            in_eof   = (w == nw - 1);
            in_cnt   = (w == nw - 1) ? 3'(len - 4*w) : 3'd4;
            #2 rdy = in_ready;
            @(posedge clk);
         end while (!rdy);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_eof   = 1'b0;
   endtask

   task automatic run_frame(input int base, input int size, input int stride,
                            input int len, input int delay, input int fid);
      int ra [16];
      int ua [16];
      int nbuf, left, pos, bad, exp_wr, cap, hi, tmo;
      logic [31:0] ew;
      nbuf = 0;
      left = len;
      exp_wr = 0;
      while (left > 0 && nbuf < 16) begin
         ra[nbuf] = base + nbuf * stride;
         cap = size - (ra[nbuf] % 4);
         ua[nbuf] = (left < cap) ? left : cap;
         exp_wr += ((ra[nbuf] % 4) + ua[nbuf] + 3) / 4;
         left -= ua[nbuf];
         nbuf++;
      end
      wr_cnt = 0; st_cnt = 0; got_last = 1'b0; run_hs = 0; max_hs = 0;
      d_base = base; d_size = size; d_stride = stride; d_delay = delay; d_k = 0;
      d_limit = nbuf;
      send_frame(fid, len, fid[0]);
      tmo = 0;
      while (!got_last && tmo < 40000) begin
         @(posedge clk);
         tmo++;
      end
      repeat (4) @(posedge clk);
      d_limit = 0;
      chk(got_last, "R4 frame closed", got_last, 1);
      chk(st_cnt == nbuf, "R4 R5 status count", st_cnt, nbuf);
      chk(wr_cnt == exp_wr, "R2 write count", wr_cnt, exp_wr);
      chk(max_hs <= 1, "R8 words taken while stalled", max_hs, 1);
      pos = 0;
      for (int k = 0; k < nbuf; k++) begin
         ew = '0;
         if (k == nbuf - 1) ew[29:16] = (len > 16383) ? 14'h3FFF : 14'(len);
         ew[9] = (k == 0);
         ew[8] = (k == nbuf - 1);
         ew[7] = (k == nbuf - 1) && (len > 16383);
         chk(st_log[k] == ew, "R6 R7 R9 status word", st_log[k], ew);
         bad = 0;
         for (int i = 0; i < ua[k]; i++)
            if (mem[ra[k] + i] !== fb(fid, pos + i)) bad++;
         chk(bad == 0, "R1 R3 byte placement", bad, 0);
         bad = 0;
         for (int a = ra[k] & ~3; a < ra[k]; a++)
            if (mem[a] !== 8'hEE) bad++;
         cap = size - (ra[k] % 4);
         hi = ((ra[k] + ua[k] + 3) & ~3);
         if (ra[k] + cap > hi) hi = ra[k] + cap;
         for (int a = ra[k] + ua[k]; a < hi; a++)
            if (mem[a] !== 8'hEE) bad++;
         chk(bad == 0, "R11 R5 untouched lanes", bad, 0);
         pos += ua[k];
      end
   endtask

   initial begin
      rst_n = 1'b0;
      in_valid = 1'b0; in_eof = 1'b0; in_data = '0; in_cnt = 3'd4;
      for (int a = 0; a < 65536; a++) mem[a] = 8'hEE;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(desc_req == 1'b1, "R10 desc_req after reset", desc_req, 1);
      chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
      chk(wr_valid == 1'b0, "R10 wr_valid after reset", wr_valid, 0);
      chk(st_valid == 1'b0, "R10 st_valid after reset", st_valid, 0);

      for (int i = 0; i < 8; i++)
         run_frame((i + 1) * 4096 + int'(VEC[i][71:56]), int'(VEC[i][55:40]),
                   int'(VEC[i][39:24]), int'(VEC[i][23:8]), int'(VEC[i][7:0]), i);

      // length saturation across three buffers
      run_frame(16'h9000, 8192, 8192, 16400, 0, 10);

      // unaligned 15-byte frame: lane enables, overflow flag cleared
      run_frame(16'hE002, 64, 256, 15, 0, 20);
      chk(first_be == 4'b1100, "R2 first write lanes", first_be, 4'b1100);
      chk(last_be == 4'b0001, "R2 last write lanes", last_be, 4'b0001);

      summary();
      $finish;
   end
endmodule